// File: doc/BRIEF.md
# Transmit Start-Threshold FIFO

This block is a byte-wide queue placed between a DMA engine that writes outgoing frame bytes and a MAC that pulls them onto the wire. It stops the MAC from starting a frame too early. A frame is released only once enough bytes are buffered to ride out bus latency. In store-and-forward mode it waits until the whole frame is buffered. Each byte carries an end-of-frame marker, so the block always knows how many complete frames it holds.

The release level comes from a 3-bit primary code. When the primary code is zero, a 3-bit legacy code supplies the level instead. Both codes are sampled only while no frame is being sent, so software may raise the level between frames.

If the MAC asks for a byte while a frame is open, the queue is empty and the frame's end marker has not yet arrived, that is an underflow. The block reports it with a one-cycle event and a sticky flag, and it drops its transmit-on state. Software then restarts the engine with a go pulse, which also empties the queue. A write into a full queue is dropped and reported.

Top module: `tx_start_fifo`

## Requirements
- R1: After reset the queue is empty, and tx_on, tx_busy, rd_valid, rd_last, udf_pulse, udf_flag and ovf_err are all 0.
- R2: A tx_go pulse empties the queue and discards stored end markers. On the next cycle tx_on is 1 and tx_busy is 0.
- R3: Primary codes 1 to 5 set the release level to 64, 128, 256, 512 and 1024 bytes (code 1 = 64, each step doubles). While tx_on is 1 and no frame is open, a frame opens (tx_busy rises) one cycle after the fill level reaches that many bytes.
- R4: Primary code 0 selects the legacy code. Legacy codes 0 to 3 set the level to 128, 256, 512 and 1024 bytes.
- R5: Primary codes 6 and 7, and legacy codes 4 to 7 when the primary code is 0, select store-and-forward mode. In this mode a frame opens only when a complete frame (a byte with wr_last = 1) is stored or the queue holds DEPTH bytes.
- R6: In any mode, a frame opens as soon as a complete frame is stored, even when the fill level is below the release level.
- R7: While a frame is open, each rd_req cycle with data present pops one byte. rd_valid, rd_data and rd_last show that byte on the following cycle. Popping the byte marked last closes the frame, and the next frame again waits for its own release condition.
- R8: rd_req while no frame is open is ignored. No byte is produced and the stored bytes are unchanged.
- R9: rd_req with a frame open and the queue empty is an underflow. On the next cycle udf_pulse is 1 for one cycle, udf_flag is 1, tx_on is 0 and tx_busy is 0.
- R10: udf_flag stays at 1 until a udf_clr pulse, which clears it on the following cycle.
- R11: A write while the queue holds DEPTH bytes is dropped, and ovf_err is 1 for one cycle on the next cycle. The stored bytes are unchanged.
- R12: No frame opens while tx_on is 0, even when a complete frame is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_go | input | 1 | Restart pulse: empty the queue and set transmit-on |
| thr_code | input | 3 | Primary release-level code |
| legacy_code | input | 3 | Fallback release-level code, used when thr_code is 0 |
| wr_en | input | 1 | Write one byte |
| wr_data | input | 8 | Byte to write |
| wr_last | input | 1 | Byte ends its frame |
| rd_req | input | 1 | MAC requests the next byte |
| udf_clr | input | 1 | Clear the sticky underflow flag |
| rd_valid | output | 1 | rd_data holds a popped byte |
| rd_data | output | 8 | Popped byte |
| rd_last | output | 1 | Popped byte ends its frame |
| tx_busy | output | 1 | A frame is open on the read side |
| tx_on | output | 1 | Transmit engine enabled |
| udf_pulse | output | 1 | One-cycle underflow event |
| udf_flag | output | 1 | Sticky underflow flag |
| ovf_err | output | 1 | One-cycle dropped-write event |

## Verification
The assertions assume that tx_go is a pulse and that the codes change only while no frame is open. They also assume a DMA side that writes while the queue is full only when the test wants to check the drop. No protocol rule limits rd_req, so the assertions must also hold when the MAC requests bytes while idle. The stimulus follows these rules: it changes the codes only after a frame has closed or after a go pulse, and it writes into a full queue only once, on purpose. A behavioural queue model in the bench predicts every output on every cycle. Named checks at the release edges confirm each level and mode.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  localparam int LVL_W = 12;

  typedef struct packed {
    logic             saf;    // wait for a whole frame
    logic [LVL_W-1:0] bytes;  // release level in bytes
  } tsf_level_t;

  // Primary code 0 defers to the legacy code; the top codes of each select store-and-forward.
  function automatic tsf_level_t tsf_decode(input logic [2:0] pri, input logic [2:0] leg);
    tsf_level_t r;
    r.saf   = 1'b0;
    r.bytes = '0;
    if (pri == 3'd0) begin
      if (leg[2]) r.saf = 1'b1;
      else        r.bytes = LVL_W'(128) << leg[1:0];
    end else if (pri >= 3'd6) begin
      r.saf = 1'b1;
    end else begin
      r.bytes = LVL_W'(32) << pri;
    end
    return r;
  endfunction

endpackage

// File: rtl/tsf_mem.sv
module tsf_mem #(
  parameter int DEPTH = 2048,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) store[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
    end
  end

  assign head = store[rptr];

endmodule

// File: rtl/tsf_level.sv
module tsf_level #(
  parameter int DEPTH = 2048
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       push_last,
  input  logic                       pop,
  input  logic                       pop_last,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       has_frame,
  output logic                       full,
  output logic                       empty
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] frames;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level  <= '0;
      frames <= '0;
    end else if (flush) begin
      level  <= '0;
      frames <= '0;
    end else begin
      case ({push, pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
      case ({push && push_last, pop && pop_last})
        2'b10:   frames <= frames + CW'(1);
        2'b01:   frames <= frames - CW'(1);
        default: frames <= frames;
      endcase
    end
  end

  assign full      = (level == CW'(DEPTH));
  assign empty     = (level == '0);
  assign has_frame = (frames != '0);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) level <= CW'(DEPTH)); // R11
  AST_FRAMES_BOUND: assert property (@(posedge clk) disable iff (!rst_n) frames <= level); // R6
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R9

endmodule

// File: rtl/tsf_gate.sv
module tsf_gate #(
  parameter int DEPTH = 2048
) (
  input  logic                   armed,
  input  logic [2:0]             thr_code,
  input  logic [2:0]             legacy_code,
  input  logic [$clog2(DEPTH):0] level,
  input  logic                   has_frame,
  input  logic                   full,
  output logic                   start
);
  import tsf_pkg::*;

  tsf_level_t lv;
  logic       level_met;

  always_comb begin
    lv        = tsf_decode(thr_code, legacy_code);
    level_met = !lv.saf && (int'(level) >= int'(lv.bytes));
    start     = armed && (full || has_frame || level_met);
  end

endmodule

// File: rtl/tx_start_fifo.sv
module tx_start_fifo #(
  parameter int DEPTH = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_go,
  input  logic [2:0] thr_code,
  input  logic [2:0] legacy_code,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  input  logic       rd_req,
  input  logic       udf_clr,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_last,
  output logic       tx_busy,
  output logic       tx_on,
  output logic       udf_pulse,
  output logic       udf_flag,
  output logic       ovf_err
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] level;
  logic          has_frame, full, empty;
  logic [8:0]    head;
  logic          start;

  // Named events for the assertions
  logic pop_ok, udf_now, push_ok, ovf_now, armed;

  assign pop_ok  = !tx_go && tx_busy && rd_req && !empty;
  assign udf_now = !tx_go && tx_busy && rd_req && empty;
  assign push_ok = !tx_go && wr_en && !full;
  assign ovf_now = !tx_go && wr_en && full;
  assign armed   = !tx_go && !tx_busy && tx_on;

  tsf_mem #(.DEPTH(DEPTH), .W(9)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (tx_go),
    .push  (push_ok),
    .pop   (pop_ok),
    .din   ({wr_last, wr_data}),
    .head  (head)
  );

  tsf_level #(.DEPTH(DEPTH)) u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_go),
    .push      (push_ok),
    .push_last (wr_last),
    .pop       (pop_ok),
    .pop_last  (head[8]),
    .level     (level),
    .has_frame (has_frame),
    .full      (full),
    .empty     (empty)
  );

  tsf_gate #(.DEPTH(DEPTH)) u_gate (
    .armed       (armed),
    .thr_code    (thr_code),
    .legacy_code (legacy_code),
    .level       (level),
    .has_frame   (has_frame),
    .full        (full),
    .start       (start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_last   <= 1'b0;
      tx_busy   <= 1'b0;
      tx_on     <= 1'b0;
      udf_pulse <= 1'b0;
      udf_flag  <= 1'b0;
      ovf_err   <= 1'b0;
    end else begin
      rd_valid  <= pop_ok;
      rd_last   <= pop_ok && head[8];
      if (pop_ok) rd_data <= head[7:0];
      udf_pulse <= udf_now;
      ovf_err   <= ovf_now;

      if (tx_go)        tx_on <= 1'b1;
      else if (udf_now) tx_on <= 1'b0;

      if (tx_go || udf_now)       tx_busy <= 1'b0;
      else if (pop_ok && head[8]) tx_busy <= 1'b0;
      else if (start)             tx_busy <= 1'b1;

      if (udf_now)      udf_flag <= 1'b1;
      else if (udf_clr) udf_flag <= 1'b0;
    end
  end

  AST_GO_ARMS: assert property (@(posedge clk) disable iff (!rst_n) tx_go |=> (tx_on && !tx_busy && level == '0)); // R2
  AST_UDF_HALTS: assert property (@(posedge clk) disable iff (!rst_n) udf_now |=> (!tx_on && !tx_busy && udf_flag)); // R9
  AST_IDLE_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (!tx_busy && rd_req) |=> !rd_valid); // R8
  AST_START_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_busy) |-> $past(tx_on)); // R12
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (ovf_now && !pop_ok) |=> $stable(level)); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (udf_flag && !udf_clr) |=> udf_flag); // R10

endmodule

// File: tb/tx_start_fifo_tb.sv
module tx_start_fifo_tb;
  localparam int DEPTH = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_go = 1'b0, wr_en = 1'b0, wr_last = 1'b0, rd_req = 1'b0, udf_clr = 1'b0;
  logic [2:0] thr_code = 3'd0, legacy_code = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic rd_valid, rd_last, tx_busy, tx_on, udf_pulse, udf_flag, ovf_err;
  logic [7:0] rd_data;

  always #2 clk = ~clk;

  tx_start_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .thr_code(thr_code), .legacy_code(legacy_code),
    .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .rd_req(rd_req), .udf_clr(udf_clr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last), .tx_busy(tx_busy),
    .tx_on(tx_on), .udf_pulse(udf_pulse), .udf_flag(udf_flag), .ovf_err(ovf_err)
  );

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  // Behavioural reference
  logic [8:0] mq[$];
  int  m_frames = 0;
  bit  m_busy = 0, m_on = 0, m_flag = 0;
  bit  m_valid = 0, m_last = 0, m_ovf = 0, m_udf = 0;
  logic [7:0] m_data = 8'd0;

  function automatic int release_bytes(input logic [2:0] p, input logic [2:0] l);
    // -1 marks store-and-forward
    case (p)
      3'd1: return 64;
      3'd2: return 128;
      3'd3: return 256;
      3'd4: return 512;
      3'd5: return 1024;
      3'd0: begin
        case (l)
          3'd0: return 128;
          3'd1: return 256;
          3'd2: return 512;
          3'd3: return 1024;
          default: return -1;
        endcase
      end
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int cnt;
    int rb;
    bit go_now;
    logic [8:0] e;
    if (!rst_n) begin
      mq.delete();
      m_frames = 0; m_busy = 0; m_on = 0; m_flag = 0;
      m_valid = 0; m_last = 0; m_ovf = 0; m_udf = 0;
    end else begin
      cnt = mq.size();
      m_valid = 0; m_last = 0; m_ovf = 0; m_udf = 0;
      if (tx_go) begin
        mq.delete(); m_frames = 0; m_on = 1; m_busy = 0;
      end else begin
        rb = release_bytes(thr_code, legacy_code);
        go_now = !m_busy && m_on && (cnt == DEPTH || m_frames > 0 || (rb > 0 && cnt >= rb));
        if (m_busy && rd_req) begin
          if (cnt > 0) begin
            e = mq.pop_front();
            m_valid = 1; m_data = e[7:0]; m_last = e[8];
            if (e[8]) begin m_busy = 0; m_frames--; end
          end else begin
            m_udf = 1; m_on = 0; m_busy = 0;
          end
        end
        if (wr_en) begin
          if (cnt == DEPTH) m_ovf = 1;
          else begin
            mq.push_back({wr_last, wr_data});
            if (wr_last) m_frames++;
          end
        end
        if (go_now) m_busy = 1;
      end
      if (m_udf) m_flag = 1;
      else if (udf_clr) m_flag = 0;
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic compare();
    bit bad;
    vectors++;
    bad = (rd_valid !== m_valid) || (rd_last !== m_last) || (tx_busy !== m_busy) ||
          (tx_on !== m_on) || (udf_pulse !== m_udf) || (udf_flag !== m_flag) ||
          (ovf_err !== m_ovf) || (m_valid && rd_data !== m_data);
    if (bad) begin
      miscompares++;
      $display("FAIL %s t=%0t: actual v=%b d=%h l=%b busy=%b on=%b udf=%b flag=%b ovf=%b expected v=%b d=%h l=%b busy=%b on=%b udf=%b flag=%b ovf=%b",
               cur_req, $time, rd_valid, rd_data, rd_last, tx_busy, tx_on, udf_pulse, udf_flag, ovf_err,
               m_valid, m_data, m_last, m_busy, m_on, m_udf, m_flag, m_ovf);
    end
  endtask

  task automatic step(input bit we, input logic [7:0] d, input bit l, input bit rr, input bit g, input bit c);
    @(negedge clk);
    compare();
    wr_en = we; wr_data = d; wr_last = l; rd_req = rr; tx_go = g; udf_clr = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'd0, 0, 0, 0, 0);
  endtask

  task automatic write_n(input int n, input bit end_frame, input logic [7:0] seed);
    for (int i = 0; i < n; i++) step(1, 8'(i) ^ seed, end_frame && (i == n - 1), 0, 0, 0);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) step(0, 8'd0, 0, 1, 0, 0);
  endtask

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    cur_req = "R1";
    idle(1);
    expect_bit("R1 tx_on after reset", tx_on, 1'b0);
    expect_bit("R1 tx_busy after reset", tx_busy, 1'b0);
    expect_bit("R1 udf_flag after reset", udf_flag, 1'b0);

    cur_req = "R12";
    thr_code = 3'd1;
    write_n(5, 1, 8'h11);
    idle(3);
    expect_bit("R12 no start while off", tx_busy, 1'b0);

    cur_req = "R2";
    step(0, 8'd0, 0, 0, 1, 0);
    idle(1);
    expect_bit("R2 tx_on after go", tx_on, 1'b1);
    idle(2);
    expect_bit("R2 stored frame flushed", tx_busy, 1'b0);

    cur_req = "R3";
    write_n(63, 0, 8'h20);
    idle(2);
    expect_bit("R3 code1 below 64", tx_busy, 1'b0);
    write_n(1, 0, 8'h5A);
    idle(2);
    expect_bit("R3 code1 at 64", tx_busy, 1'b1);
    cur_req = "R7";
    write_n(36, 1, 8'h33);
    read_n(100);
    idle(2);
    expect_bit("R7 frame closed", tx_busy, 1'b0);
    write_n(64, 0, 8'h44);
    idle(2);
    for (int i = 0; i < 30; i++) step(1, 8'(i) ^ 8'h77, i == 29, 1, 0, 0);
    read_n(70);
    idle(2);

    cur_req = "R3";
    thr_code = 3'd5;
    write_n(1023, 0, 8'h01);
    idle(2);
    expect_bit("R3 code5 below 1024", tx_busy, 1'b0);
    write_n(1, 0, 8'hC3);
    idle(2);
    expect_bit("R3 code5 at 1024", tx_busy, 1'b1);
    read_n(1024);
    cur_req = "R9";
    read_n(1);
    idle(1);
    expect_bit("R9 underflow pulse", udf_pulse, 1'b1);
    expect_bit("R9 tx_on dropped", tx_on, 1'b0);
    expect_bit("R9 flag set", udf_flag, 1'b1);
    idle(2);
    cur_req = "R10";
    expect_bit("R10 flag sticky", udf_flag, 1'b1);
    step(0, 8'd0, 0, 0, 0, 1);
    idle(1);
    expect_bit("R10 flag cleared", udf_flag, 1'b0);

    cur_req = "R4";
    step(0, 8'd0, 0, 0, 1, 0);
    thr_code = 3'd0; legacy_code = 3'd1;
    write_n(255, 0, 8'h60);
    idle(2);
    expect_bit("R4 legacy1 below 256", tx_busy, 1'b0);
    write_n(1, 0, 8'h61);
    idle(2);
    expect_bit("R4 legacy1 at 256", tx_busy, 1'b1);
    write_n(1, 1, 8'h62);
    read_n(257);
    idle(2);

    cur_req = "R5";
    thr_code = 3'd7;
    write_n(1500, 0, 8'h90);
    idle(2);
    expect_bit("R5 saf waits for end", tx_busy, 1'b0);
    write_n(1, 1, 8'h91);
    idle(2);
    expect_bit("R5 saf frame complete", tx_busy, 1'b1);
    read_n(1501);
    idle(2);
    thr_code = 3'd0; legacy_code = 3'd4;
    write_n(10, 0, 8'hA0);
    idle(3);
    expect_bit("R5 legacy saf partial", tx_busy, 1'b0);
    write_n(DEPTH - 10, 0, 8'hB0);
    idle(2);
    expect_bit("R5 saf starts when full", tx_busy, 1'b1);
    cur_req = "R11";
    write_n(1, 1, 8'hEE);
    idle(1);
    expect_bit("R11 overflow flagged", ovf_err, 1'b1);
    read_n(DEPTH);
    read_n(1);
    idle(2);

    cur_req = "R6";
    step(0, 8'd0, 0, 0, 1, 0);
    thr_code = 3'd3;
    write_n(20, 1, 8'hD0);
    idle(2);
    expect_bit("R6 short frame starts", tx_busy, 1'b1);
    read_n(20);
    idle(2);

    cur_req = "R8";
    thr_code = 3'd1;
    write_n(10, 0, 8'hE0);
    read_n(5);
    idle(1);
    expect_bit("R8 idle read gives no byte", rd_valid, 1'b0);
    write_n(54, 1, 8'hE5);
    idle(2);
    read_n(64);
    idle(3);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule